// File: doc/BRIEF.md
# PWM Action Qualifier with Continuous Software Force

This block turns time-base events into two PWM output levels, `pwm_a` and `pwm_b`. Each time-base tick can carry four kinds of event: the counter reaching zero, the counter reaching the shared period, the counter matching compare value A while counting up, and the counter matching compare value B while counting up. The zero and period strobes come from an external time-base counter. The two compare events are detected inside the block from the counter value, the count direction and the two compare inputs. Each output has its own action register, with a 2-bit field for every event kind. A field can leave the output alone, drive it low, drive it high or toggle it. Outputs change only on cycles where `tick` is high.

A continuous software-force register can hold either output at a fixed level, and that level overrides every event action. Software writes this register into a shadow copy. The copy that is actually applied reloads from the shadow at a point chosen by a reload-policy field: at counter zero, at period, at either of them, or at once on the write. Programming an output with high-at-zero, high-at-period and low-at-compare gives an edge-aligned waveform whose duty is set by its compare value. Swapping low and high in that pattern inverts the polarity.

Top module: `pwm_aq_force`

## Requirements
- R1: After reset both outputs are low, and every register is zero: no actions, force shadow and active copies set to no force, and reload policy set to counter zero.
- R2: The outputs change only on cycles where `tick` is high. Event strobes and register writes made without a tick leave both outputs unchanged.
- R3: The per-output action registers are at address 0 (output A) and address 1 (output B). Each field is 2 bits: zero event in bits 1:0, period event in 3:2, compare-A-up in 5:4, compare-B-up in 9:8. The encodings are 00 no action, 01 drive low, 10 drive high, 11 toggle.
- R4: A compare event fires on a tick only when `ctr_up` is high and `ctr_value` equals that compare input. There is no compare event while counting down.
- R5: When several events with non-00 fields occur in one tick, one action is applied, chosen in this order: compare-A over compare-B, compare-B over period, period over zero. An event whose field is 00 does not block a lower-priority event.
- R6: The force register is at address 2, with output A in bits 1:0 and output B in bits 3:2. An applied value of 01 forces the output low and 10 forces it high on every tick, overriding all actions. Values 00 and 11 leave the event actions in control.
- R7: The reload policy is in bits 7:6 of address 3: 00 reloads at a zero tick, 01 at a period tick, 10 at either. At such a tick the shadow is copied to the applied copy and already governs that tick's output. Until then, force writes have no effect on the outputs.
- R8: With reload policy 11, a force write updates the applied copy in the same cycle. The forced level appears at the first tick after the write cycle.
- R9: With action values 0x001A (A) and 0x010A (B), both outputs go high at zero and at the shared period, and each goes low at its own compare match. With 0x0025 and 0x0205 the waveforms are exactly inverted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Time-base tick; events are qualified by it |
| ctr_zero | input | 1 | Counter-at-zero strobe |
| ctr_period | input | 1 | Counter-at-period strobe |
| ctr_up | input | 1 | Counter direction, 1 = counting up |
| ctr_value | input | CNT_W | Current counter value |
| cmp_a_val | input | CNT_W | Compare value A |
| cmp_b_val | input | CNT_W | Compare value B |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | REG_W | Register write data |
| pwm_a | output | 1 | PWM output A |
| pwm_b | output | 1 | PWM output B |

## Verification
The output flops are the block's only visible state. A wrong level in either flop, or in the applied force copy, appears at the pins on the next tick and stays there until an event or force corrects it. A shadow that reloads at the wrong time shows up at the first zero or period tick: the output either stays forced when it should follow its actions, or ignores a pending force. The waveform checks therefore sample the outputs after every tick, around each reload point and each compare match.

// File: rtl/aq_pkg.sv
package aq_pkg;

    typedef enum logic [1:0] {
        ACT_NONE   = 2'b00,
        ACT_LOW    = 2'b01,
        ACT_HIGH   = 2'b10,
        ACT_TOGGLE = 2'b11
    } act_e;

    typedef enum logic [1:0] {
        FRC_OFF  = 2'b00,
        FRC_LOW  = 2'b01,
        FRC_HIGH = 2'b10,
        FRC_DIS  = 2'b11
    } frc_e;

    typedef enum logic [1:0] {
        RLD_ZERO   = 2'b00,
        RLD_PERIOD = 2'b01,
        RLD_EITHER = 2'b10,
        RLD_NOW    = 2'b11
    } rld_e;

    typedef struct packed {
        act_e cmpb_up;
        act_e cmpa_up;
        act_e period;
        act_e zero;
    } act_cfg_t;

    typedef struct packed {
        logic cmpb_up;
        logic cmpa_up;
        logic period;
        logic zero;
    } evt_t;

    // field positions decoded by the action and force registers
    localparam int unsigned ZERO_LSB  = 0;
    localparam int unsigned PRD_LSB   = 2;
    localparam int unsigned CAU_LSB   = 4;
    localparam int unsigned CBU_LSB   = 8;
    localparam int unsigned ACT_SPAN  = 10;
    localparam int unsigned RLD_LSB   = 6;
    localparam int unsigned FRC_FLD_W = 2;

    function automatic act_cfg_t unpack_act(input logic [ACT_SPAN-1:0] w);
        act_cfg_t c;
        c.zero    = act_e'(w[ZERO_LSB +: 2]);
        c.period  = act_e'(w[PRD_LSB  +: 2]);
        c.cmpa_up = act_e'(w[CAU_LSB  +: 2]);
        c.cmpb_up = act_e'(w[CBU_LSB  +: 2]);
        return c;
    endfunction

    // highest-priority event with a non-empty action wins
    function automatic act_e pick_action(input evt_t e, input act_cfg_t c);
        act_e s;
        s = ACT_NONE;
        if (e.zero    && c.zero    != ACT_NONE) s = c.zero;
        if (e.period  && c.period  != ACT_NONE) s = c.period;
        if (e.cmpb_up && c.cmpb_up != ACT_NONE) s = c.cmpb_up;
        if (e.cmpa_up && c.cmpa_up != ACT_NONE) s = c.cmpa_up;
        return s;
    endfunction

    function automatic logic apply_act(input act_e a, input logic cur);
        logic r;
        case (a)
            ACT_LOW:    r = 1'b0;
            ACT_HIGH:   r = 1'b1;
            ACT_TOGGLE: r = ~cur;
            default:    r = cur;
        endcase
        return r;
    endfunction

    function automatic logic reload_due(input rld_e m, input logic z, input logic p);
        logic r;
        case (m)
            RLD_ZERO:   r = z;
            RLD_PERIOD: r = p;
            RLD_EITHER: r = z | p;
            default:    r = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/aq_evt_gen.sv
module aq_evt_gen
    import aq_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic             tick,
    input  logic             ctr_zero,
    input  logic             ctr_period,
    input  logic             ctr_up,
    input  logic [CNT_W-1:0] ctr_value,
    input  logic [CNT_W-1:0] cmp_a_val,
    input  logic [CNT_W-1:0] cmp_b_val,
    output evt_t             evt
);

    logic hit_a;
    logic hit_b;

    always_comb begin
        hit_a       = (ctr_value == cmp_a_val);
        hit_b       = (ctr_value == cmp_b_val);
        evt.zero    = tick & ctr_zero;
        evt.period  = tick & ctr_period;
        evt.cmpa_up = tick & ctr_up & hit_a;
        evt.cmpb_up = tick & ctr_up & hit_b;
    end

endmodule

// File: rtl/aq_cfg_regs.sv
module aq_cfg_regs
    import aq_pkg::*;
#(
    parameter int unsigned N_OUT    = 2,
    parameter int unsigned REG_W    = 16,
    parameter int unsigned ADDR_W   = 2,
    parameter int unsigned ACT_BASE = 0,
    parameter int unsigned FRC_ADDR = 2,
    parameter int unsigned RLD_ADDR = 3
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_en,
    input  logic [ADDR_W-1:0]      wr_addr,
    input  logic [REG_W-1:0]       wr_data,
    output act_cfg_t [N_OUT-1:0]   act_cfg,
    output rld_e                   rld_mode,
    output logic                   frc_wr
);

    localparam logic [ADDR_W-1:0] FRC_A = ADDR_W'(FRC_ADDR);
    localparam logic [ADDR_W-1:0] RLD_A = ADDR_W'(RLD_ADDR);

    act_cfg_t act_q [N_OUT];
    rld_e     rld_q;
    logic     unused_wr;

    assign unused_wr = ^wr_data;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N_OUT; i++) begin
                act_q[i] <= '0;
            end
            rld_q <= RLD_ZERO;
        end else if (wr_en) begin
            for (int i = 0; i < N_OUT; i++) begin
                if (wr_addr == ADDR_W'(ACT_BASE + i)) begin
                    act_q[i] <= unpack_act(wr_data[ACT_SPAN-1:0]);
                end
            end
            if (wr_addr == RLD_A) begin
                rld_q <= rld_e'(wr_data[RLD_LSB +: 2]);
            end
        end
    end

    for (genvar g = 0; g < N_OUT; g++) begin : g_cfg_out
        assign act_cfg[g] = act_q[g];
    end

    assign rld_mode = rld_q;
    assign frc_wr   = wr_en & (wr_addr == FRC_A);

endmodule

// File: rtl/aq_force_ctl.sv
module aq_force_ctl
    import aq_pkg::*;
#(
    parameter int unsigned N_OUT = 2,
    localparam int unsigned FRC_W = FRC_FLD_W * N_OUT
) (
    input  logic             clk,
    input  logic             rst,
    input  evt_t             evt,
    input  rld_e             rld_mode,
    input  logic             frc_wr,
    input  logic [FRC_W-1:0] frc_wdata,
    output logic [FRC_W-1:0] frc_active,
    output logic [FRC_W-1:0] frc_eff,
    output logic             reload_now
);

    logic [FRC_W-1:0] shadow_q;
    logic [FRC_W-1:0] active_q;
    logic             direct_wr;

    // evt is already qualified by tick
    assign reload_now = reload_due(rld_mode, evt.zero, evt.period);
    assign direct_wr  = frc_wr & (rld_mode == RLD_NOW);

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow_q <= '0;
        end else if (frc_wr) begin
            shadow_q <= frc_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= '0;
        end else if (reload_now) begin
            active_q <= shadow_q;
        end else if (direct_wr) begin
            active_q <= frc_wdata;
        end
    end

    // a reloading tick is already governed by the new copy
    assign frc_eff    = reload_now ? shadow_q : active_q;
    assign frc_active = active_q;

endmodule

// File: rtl/aq_out_chan.sv
module aq_out_chan
    import aq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     tick,
    input  evt_t     evt,
    input  act_cfg_t cfg,
    input  frc_e     frc,
    output logic     level
);

    act_e sel;
    logic nxt;

    always_comb begin
        sel = pick_action(evt, cfg);
        case (frc)
            FRC_LOW:  nxt = 1'b0;
            FRC_HIGH: nxt = 1'b1;
            default:  nxt = apply_act(sel, level);
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            level <= 1'b0;
        end else if (tick) begin
            level <= nxt;
        end
    end

endmodule

// File: rtl/pwm_aq_force.sv
module pwm_aq_force
    import aq_pkg::*;
#(
    parameter int unsigned CNT_W    = 16,
    parameter int unsigned REG_W    = 16,
    parameter int unsigned ADDR_W   = 2,
    parameter int unsigned ACT_BASE = 0,
    parameter int unsigned FRC_ADDR = 2,
    parameter int unsigned RLD_ADDR = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              ctr_zero,
    input  logic              ctr_period,
    input  logic              ctr_up,
    input  logic [CNT_W-1:0]  ctr_value,
    input  logic [CNT_W-1:0]  cmp_a_val,
    input  logic [CNT_W-1:0]  cmp_b_val,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [REG_W-1:0]  wr_data,
    output logic              pwm_a,
    output logic              pwm_b
);

    localparam int unsigned N_OUT = 2;
    localparam int unsigned FRC_W = FRC_FLD_W * N_OUT;

    evt_t                 evt;
    act_cfg_t [N_OUT-1:0] act_cfg;
    rld_e                 rld_mode;
    logic                 frc_wr;
    logic [FRC_W-1:0]     frc_active;
    logic [FRC_W-1:0]     frc_eff;
    logic                 reload_now;
    logic [N_OUT-1:0]     lvl;

    aq_evt_gen #(.CNT_W(CNT_W)) u_evt (
        .tick       (tick),
        .ctr_zero   (ctr_zero),
        .ctr_period (ctr_period),
        .ctr_up     (ctr_up),
        .ctr_value  (ctr_value),
        .cmp_a_val  (cmp_a_val),
        .cmp_b_val  (cmp_b_val),
        .evt        (evt)
    );

    aq_cfg_regs #(
        .N_OUT    (N_OUT),
        .REG_W    (REG_W),
        .ADDR_W   (ADDR_W),
        .ACT_BASE (ACT_BASE),
        .FRC_ADDR (FRC_ADDR),
        .RLD_ADDR (RLD_ADDR)
    ) u_cfg (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .act_cfg  (act_cfg),
        .rld_mode (rld_mode),
        .frc_wr   (frc_wr)
    );

    aq_force_ctl #(.N_OUT(N_OUT)) u_frc (
        .clk        (clk),
        .rst        (rst),
        .evt        (evt),
        .rld_mode   (rld_mode),
        .frc_wr     (frc_wr),
        .frc_wdata  (wr_data[FRC_W-1:0]),
        .frc_active (frc_active),
        .frc_eff    (frc_eff),
        .reload_now (reload_now)
    );

    for (genvar g = 0; g < N_OUT; g++) begin : g_chan
        aq_out_chan u_chan (
            .clk   (clk),
            .rst   (rst),
            .tick  (tick),
            .evt   (evt),
            .cfg   (act_cfg[g]),
            .frc   (frc_e'(frc_eff[FRC_FLD_W*g +: FRC_FLD_W])),
            .level (lvl[g])
        );
    end

    assign pwm_a = lvl[0];
    assign pwm_b = lvl[1];

endmodule

// File: rtl/aq_force_chk.sv
module aq_force_chk #(
    parameter int unsigned ADDR_W   = 2,
    parameter int unsigned REG_W    = 16,
    parameter int unsigned FRC_ADDR = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              tick,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [REG_W-1:0]  wr_data,
    input logic [1:0]        rld_mode,
    input logic [3:0]        frc_active,
    input logic [3:0]        frc_eff,
    input logic              reload_now,
    input logic              pwm_a,
    input logic              pwm_b
);

    logic imm_wr;
    assign imm_wr = wr_en && (wr_addr == ADDR_W'(FRC_ADDR)) && (rld_mode == 2'b11);

    assert_reset_low_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!pwm_a && !pwm_b));

    assert_hold_no_tick_R2: assert property (@(posedge clk) disable iff (rst)
        !tick |=> ($stable(pwm_a) && $stable(pwm_b)));

    assert_force_lvl_low_R6: assert property (@(posedge clk) disable iff (rst)
        (tick && frc_eff[1:0] == 2'b01) |=> !pwm_a);

    assert_force_lvl_high_R6: assert property (@(posedge clk) disable iff (rst)
        (tick && frc_eff[3:2] == 2'b10) |=> pwm_b);

    assert_shadow_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (!reload_now && !imm_wr) |=> $stable(frc_active));

    assert_imm_load_R8: assert property (@(posedge clk) disable iff (rst)
        imm_wr |=> (frc_active == $past(wr_data[3:0])));

endmodule

bind pwm_aq_force aq_force_chk #(
    .ADDR_W   (ADDR_W),
    .REG_W    (REG_W),
    .FRC_ADDR (FRC_ADDR)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .tick       (tick),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .rld_mode   (rld_mode),
    .frc_active (frc_active),
    .frc_eff    (frc_eff),
    .reload_now (reload_now),
    .pwm_a      (pwm_a),
    .pwm_b      (pwm_b)
);

// File: tb/pwm_aq_force_tb.sv
module pwm_aq_force_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        tick;
    logic        ctr_zero;
    logic        ctr_period;
    logic        ctr_up;
    logic [15:0] ctr_value;
    logic [15:0] cmp_a_val;
    logic [15:0] cmp_b_val;
    logic        wr_en;
    logic [1:0]  wr_addr;
    logic [15:0] wr_data;
    logic        pwm_a;
    logic        pwm_b;

    int n_vec = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    pwm_aq_force dut_i (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .ctr_zero   (ctr_zero),
        .ctr_period (ctr_period),
        .ctr_up     (ctr_up),
        .ctr_value  (ctr_value),
        .cmp_a_val  (cmp_a_val),
        .cmp_b_val  (cmp_b_val),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .pwm_a      (pwm_a),
        .pwm_b      (pwm_b)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic step(input logic z, input logic p, input logic up, input logic [15:0] v);
        @(negedge clk);
        tick = 1'b1; ctr_zero = z; ctr_period = p; ctr_up = up; ctr_value = v;
        @(negedge clk);
        tick = 1'b0; ctr_zero = 1'b0; ctr_period = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 reset pwm_a", pwm_a, 1'b0);
        chk("R1 reset pwm_b", pwm_b, 1'b0);
        step(1, 1, 1, 16'hFFFF);
        chk("R1 no actions after reset A", pwm_a, 1'b0);
        chk("R1 no actions after reset B", pwm_b, 1'b0);
    endtask

    task automatic t_actions();
        cmp_a_val = 16'd10; cmp_b_val = 16'd5;
        wr(2'd0, 16'h0002);
        step(1, 0, 1, 16'hFFFF);
        chk("R3 zero high A", pwm_a, 1'b1);
        chk("R3 unprogrammed B", pwm_b, 1'b0);
        wr(2'd0, 16'h0001);
        @(negedge clk); ctr_zero = 1'b1;
        repeat (2) @(negedge clk);
        chk("R2 no tick no change", pwm_a, 1'b1);
        ctr_zero = 1'b0;
        step(1, 0, 1, 16'hFFFF);
        chk("R3 zero low A", pwm_a, 1'b0);
        wr(2'd0, 16'h0003);
        step(1, 0, 1, 16'hFFFF);
        chk("R3 toggle 1", pwm_a, 1'b1);
        step(1, 0, 1, 16'hFFFF);
        chk("R3 toggle 2", pwm_a, 1'b0);
        wr(2'd0, 16'h0008);
        step(0, 1, 1, 16'hFFFF);
        chk("R3 period high A", pwm_a, 1'b1);
        wr(2'd0, 16'h0100);
        step(0, 0, 1, 16'd5);
        chk("R3 compare-B low on A", pwm_a, 1'b0);
    endtask

    task automatic t_compare();
        wr(2'd0, 16'h0020);
        step(0, 0, 0, 16'd10);
        chk("R4 no compare counting down", pwm_a, 1'b0);
        step(0, 0, 1, 16'd9);
        chk("R4 no compare on mismatch", pwm_a, 1'b0);
        step(0, 0, 1, 16'd10);
        chk("R4 compare-A up high", pwm_a, 1'b1);
    endtask

    task automatic t_priority();
        wr(2'd0, 16'h0006);
        step(1, 1, 1, 16'hFFFF);
        chk("R5 period over zero", pwm_a, 1'b0);
        wr(2'd0, 16'h0024);
        step(0, 1, 1, 16'd10);
        chk("R5 compare over period", pwm_a, 1'b1);
        cmp_b_val = 16'd10;
        wr(2'd0, 16'h0210);
        step(0, 0, 1, 16'd10);
        chk("R5 compare-A over compare-B", pwm_a, 1'b0);
        wr(2'd0, 16'h0002);
        step(1, 0, 1, 16'd10);
        chk("R5 empty field does not block", pwm_a, 1'b1);
        cmp_b_val = 16'd5;
    endtask

    task automatic t_force();
        wr(2'd0, 16'h0001);
        step(1, 0, 1, 16'hFFFF);
        chk("R3 zero low before force", pwm_a, 1'b0);
        wr(2'd2, 16'h0002);
        step(0, 1, 1, 16'hFFFF);
        chk("R7 shadow held until zero", pwm_a, 1'b0);
        step(1, 0, 1, 16'hFFFF);
        chk("R7 reload at zero governs tick", pwm_a, 1'b1);
        step(1, 0, 1, 16'hFFFF);
        chk("R6 force high persists", pwm_a, 1'b1);
        wr(2'd2, 16'h0003);
        step(1, 0, 1, 16'hFFFF);
        chk("R6 disabled force yields to action", pwm_a, 1'b0);
        wr(2'd1, 16'h0002);
        step(1, 0, 1, 16'hFFFF);
        chk("R3 B zero high", pwm_b, 1'b1);
        wr(2'd2, 16'h0004);
        wr(2'd3, 16'h0040);
        step(1, 0, 1, 16'hFFFF);
        chk("R7 period policy ignores zero", pwm_b, 1'b1);
        step(0, 1, 1, 16'hFFFF);
        chk("R7 period policy reloads", pwm_b, 1'b0);
        wr(2'd3, 16'h0080);
        wr(2'd2, 16'h0008);
        step(1, 0, 1, 16'hFFFF);
        chk("R7 either policy at zero", pwm_b, 1'b1);
        wr(2'd2, 16'h0004);
        step(0, 1, 1, 16'hFFFF);
        chk("R7 either policy at period", pwm_b, 1'b0);
        chk("R6 A untouched by B force", pwm_a, 1'b0);
    endtask

    task automatic t_immediate();
        wr(2'd3, 16'h00C0);
        wr(2'd2, 16'h0008);
        repeat (2) @(negedge clk);
        chk("R2 immediate write waits for tick", pwm_b, 1'b0);
        step(0, 0, 1, 16'hFFFF);
        chk("R8 immediate force high", pwm_b, 1'b1);
        wr(2'd2, 16'h0004);
        step(0, 0, 1, 16'hFFFF);
        chk("R8 immediate force low", pwm_b, 1'b0);
        wr(2'd2, 16'h0000);
        wr(2'd3, 16'h0000);
    endtask

    task automatic run_wave(input logic inv, input string tag);
        cmp_a_val = 16'd3; cmp_b_val = 16'd6;
        for (int c = 0; c < 8; c++) begin
            step(c == 0, c == 7, 1, 16'(c));
            chk({tag, " A"}, pwm_a, ((c < 3) || (c == 7)) ^ inv);
            chk({tag, " B"}, pwm_b, ((c < 6) || (c == 7)) ^ inv);
        end
    endtask

    task automatic t_polarity();
        wr(2'd0, 16'h001A);
        wr(2'd1, 16'h010A);
        run_wave(1'b0, "R9 normal");
        wr(2'd0, 16'h0025);
        wr(2'd1, 16'h0205);
        run_wave(1'b1, "R9 inverted");
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        rst = 1'b1; tick = 1'b0; ctr_zero = 1'b0; ctr_period = 1'b0; ctr_up = 1'b0;
        ctr_value = 16'hFFFF; cmp_a_val = 16'd0; cmp_b_val = 16'd0;
        wr_en = 1'b0; wr_addr = 2'd0; wr_data = 16'd0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_actions();
        t_compare();
        t_priority();
        t_force();
        t_immediate();
        t_polarity();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule